// File: doc/BRIEF.md
# Cursor Pattern Store and Position Registers

This block sits in a colour look-up output stage and keeps everything the host programs for a two-plane hardware cursor: a byte-wide pattern memory and a pair of 12-bit screen coordinates. The cursor is either 32x32 or 64x64 pixels with two bits per pixel, so its pattern takes 256 or 1024 bytes. The host reaches the pattern through a single data select that reads or writes one byte and then advances an internal pointer. The low eight pointer bits come from the shared palette write index. In the large mode the two top bits come from the bank field of a command register, and they are reloaded whenever that register or the palette write index is written.

The coordinates are written as four byte registers: a low byte and a high nibble for each axis. The block presents the top-left screen position of the cursor. This is the stored coordinate minus the cursor dimension, a signed value, so the cursor can hang off the left or top edge. It also gives the row offset that the pattern fetch logic applies in the small mode. Mixing the cursor into the pixel stream belongs to another block.

Top module: `hwcur_store`

## Requirements
- R1: After reset the pointer is 0, both coordinates are 0, `host_rdata` is 0x00, and the effective positions equal minus the cursor dimension.
- R2: A write on select 0xB stores `host_wdata` at the current pointer. A read on select 0xB returns the byte at the pointer on `host_rdata` one cycle later. Either access then advances the pointer by one.
- R3: In 64x64 mode the pointer wraps from 1023 to 0. In 32x32 mode it wraps from 255 to 0, and only its low eight bits address the pattern memory.
- R4: A write on select 0x0 (palette write index) loads pointer bits 7:0 from `host_wdata`. It loads bits 9:8 from `bank_sel` in 64x64 mode and clears them in 32x32 mode.
- R5: A pulse on `bank_load` copies `bank_sel` into pointer bits 9:8 in 64x64 mode and keeps bits 7:0. In 32x32 mode the pulse has no effect.
- R6: Selects 0xC and 0xE load bits 7:0 of X and Y. Selects 0xD and 0xF load bits 11:8 of X and Y from `host_wdata[3:0]`. Each write leaves the other part of the coordinate unchanged.
- R7: A read of 0xC or 0xE returns coordinate bits 7:0. A read of 0xD or 0xF returns bits 11:8 in bits 3:0, with bits 7:4 zero.
- R8: `eff_x` and `eff_y` equal the X and Y coordinates minus 64 (64x64) or 32 (32x32), as 13-bit two's complement. They follow a change of `size_big` in the same cycle.
- R9: `row_off` is 32 in 32x32 mode and 0 in 64x64 mode.
- R10: With parameter `LARGE_OK` = 0 the block stays in 32x32 mode whatever `size_big` says.
- R11: A read on any select other than 0xB to 0xF returns 0x00. When `host_wr` and `host_rd` are both high, only the write takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_sel | input | 4 | Register select of the current access |
| host_wr | input | 1 | Write strobe, one access per cycle |
| host_rd | input | 1 | Read strobe, one access per cycle |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, valid the cycle after a read |
| size_big | input | 1 | Cursor size: 1 = 64x64, 0 = 32x32 |
| bank_sel | input | 2 | Pointer bank bits from the command register |
| bank_load | input | 1 | Pulse: command register written this cycle |
| eff_x | output | 13 | Signed effective left edge |
| eff_y | output | 13 | Signed effective top edge |
| row_off | output | 6 | Pattern row offset for the fetch logic |

## Verification
The hardest cases to reach from the ports are the ones where pointer state carries across a change of mode. Examples are a small-mode access while bits 9:8 still hold a bank from large mode, and a bank load in the same cycle as a data access. Every byte of the pattern memory is filled first, so any pointer that goes wrong shows up as a wrong byte on a later read. The directed steps then run each wrap boundary in both modes. After that, a long random mix of selects, strobes, bank loads and size flips runs against a behavioural model, and every cycle is compared.

// File: rtl/hwcur_pkg.sv
package hwcur_pkg;
    localparam logic [3:0] SEL_PAL_WIDX = 4'h0;
    localparam logic [3:0] SEL_PAT_DATA = 4'hB;
    localparam logic [3:0] SEL_X_LO     = 4'hC;
    localparam logic [3:0] SEL_X_HI     = 4'hD;
    localparam logic [3:0] SEL_Y_LO     = 4'hE;
    localparam logic [3:0] SEL_Y_HI     = 4'hF;

    typedef enum logic {
        RSRC_BYTE = 1'b0,
        RSRC_RAM  = 1'b1
    } rsrc_e;

    function automatic logic is_pos_sel(input logic [3:0] s);
        return (s == SEL_X_LO) || (s == SEL_X_HI) || (s == SEL_Y_LO) || (s == SEL_Y_HI);
    endfunction
endpackage

// File: rtl/hwcur_ptr.sv
module hwcur_ptr #(
    parameter int LOW_W  = 8,
    parameter int BANK_W = 2,
    parameter int ADDR_W = LOW_W + BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              idx_wr,
    input  logic [LOW_W-1:0]  idx_val,
    input  logic              bank_load,
    input  logic [BANK_W-1:0] bank_sel,
    input  logic              big,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.ptr = st_q.ptr + 1'b1;
            if (!big) st_d.ptr[ADDR_W-1:LOW_W] = '0;
        end
        if (idx_wr) begin
            st_d.ptr[LOW_W-1:0]      = idx_val;
            st_d.ptr[ADDR_W-1:LOW_W] = big ? bank_sel : '0;
        end else if (bank_load && big) begin
            st_d.ptr[ADDR_W-1:LOW_W] = bank_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ptr = st_q.ptr;

    // R4
    idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_wr |=> ptr[LOW_W-1:0] == $past(idx_val));

    // R3
    small_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !big) |=> ptr[ADDR_W-1:LOW_W] == '0);

    // R2
    step_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !idx_wr) |=> ptr[LOW_W-1:0] == LOW_W'($past(ptr[LOW_W-1:0]) + 1'b1));

    // R5
    bank_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_load && !big && !step && !idx_wr) |=> $stable(ptr));
endmodule

// File: rtl/hwcur_patram.sv
module hwcur_patram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 10,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              re,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
        if (re) rdata_q   <= mem[addr];
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/hwcur_pos.sv
module hwcur_pos
    import hwcur_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int POS_W     = 12,
    parameter int BIG_DIM   = 64,
    parameter int SMALL_DIM = 32,
    parameter int OUT_W     = POS_W + 1,
    parameter int OFF_W     = $clog2(SMALL_DIM) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr,
    input  logic [3:0]              sel,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [3:0]              rd_sel,
    output logic [DATA_W-1:0]       rd_byte,
    input  logic                    big,
    output logic signed [OUT_W-1:0] eff_x,
    output logic signed [OUT_W-1:0] eff_y,
    output logic [OFF_W-1:0]        row_off
);
    localparam int HI_W = POS_W - DATA_W;

    typedef struct packed {
        logic [POS_W-1:0] x;
        logic [POS_W-1:0] y;
    } pos_t;

    pos_t pos_d, pos_q;
    logic [OUT_W-1:0] dim;

    always_comb begin
        pos_d = pos_q;
        if (wr) begin
            case (sel)
                SEL_X_LO: pos_d.x[DATA_W-1:0]     = wdata;
                SEL_X_HI: pos_d.x[POS_W-1:DATA_W] = wdata[HI_W-1:0];
                SEL_Y_LO: pos_d.y[DATA_W-1:0]     = wdata;
                SEL_Y_HI: pos_d.y[POS_W-1:DATA_W] = wdata[HI_W-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pos_q <= '0;
        else        pos_q <= pos_d;
    end

    always_comb begin
        case (rd_sel)
            SEL_X_LO: rd_byte = pos_q.x[DATA_W-1:0];
            SEL_X_HI: rd_byte = DATA_W'(pos_q.x[POS_W-1:DATA_W]);
            SEL_Y_LO: rd_byte = pos_q.y[DATA_W-1:0];
            SEL_Y_HI: rd_byte = DATA_W'(pos_q.y[POS_W-1:DATA_W]);
            default:  rd_byte = '0;
        endcase
    end

    assign dim     = big ? OUT_W'(BIG_DIM) : OUT_W'(SMALL_DIM);
    assign eff_x   = $signed({1'b0, pos_q.x}) - $signed(dim);
    assign eff_y   = $signed({1'b0, pos_q.y}) - $signed(dim);
    assign row_off = big ? '0 : OFF_W'(SMALL_DIM);

    // R6
    xhi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_X_HI) |=> pos_q.x[POS_W-1:DATA_W] == $past(wdata[HI_W-1:0]));

    // R6
    xlo_keep_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == SEL_X_LO) |=> $stable(pos_q.x[POS_W-1:DATA_W]));

    // R8
    size_moves_eff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (big != $past(big) && $stable(pos_q.y)) |-> eff_y != $past(eff_y));
endmodule

// File: rtl/hwcur_store.sv
module hwcur_store
    import hwcur_pkg::*;
#(
    parameter bit LARGE_OK  = 1'b1,
    parameter int DATA_W    = 8,
    parameter int POS_W     = 12,
    parameter int BIG_DIM   = 64,
    parameter int SMALL_DIM = 32,
    parameter int PLANES    = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [3:0]         host_sel,
    input  logic               host_wr,
    input  logic               host_rd,
    input  logic [7:0]         host_wdata,
    output logic [7:0]         host_rdata,
    input  logic               size_big,
    input  logic [1:0]         bank_sel,
    input  logic               bank_load,
    output logic signed [12:0] eff_x,
    output logic signed [12:0] eff_y,
    output logic [5:0]         row_off
);
    localparam int BIG_BYTES   = BIG_DIM * BIG_DIM * PLANES / DATA_W;
    localparam int SMALL_BYTES = SMALL_DIM * SMALL_DIM * PLANES / DATA_W;
    localparam int ADDR_W      = $clog2(BIG_BYTES);
    localparam int LOW_W       = $clog2(SMALL_BYTES);
    localparam int BANK_W      = ADDR_W - LOW_W;
    localparam int OUT_W       = POS_W + 1;
    localparam int OFF_W       = $clog2(SMALL_DIM) + 1;

    typedef struct packed {
        rsrc_e             src;
        logic [DATA_W-1:0] byte_v;
    } rd_t;

    rd_t rd_d, rd_q;

    logic              big;
    logic              rd_fire, pat_wr, pat_rd, idx_wr;
    logic [ADDR_W-1:0] ptr, ram_addr;
    logic [DATA_W-1:0] ram_rdata, pos_byte;

    generate
        if (LARGE_OK) begin : g_two_sizes
            assign big = size_big;
        end else begin : g_small_only
            assign big = 1'b0;
        end
    endgenerate

    assign rd_fire = host_rd && !host_wr;
    assign pat_wr  = host_wr && (host_sel == SEL_PAT_DATA);
    assign pat_rd  = rd_fire && (host_sel == SEL_PAT_DATA);
    assign idx_wr  = host_wr && (host_sel == SEL_PAL_WIDX);

    hwcur_ptr #(.LOW_W(LOW_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx_wr    (idx_wr),
        .idx_val   (host_wdata[LOW_W-1:0]),
        .bank_load (bank_load),
        .bank_sel  (bank_sel[BANK_W-1:0]),
        .big       (big),
        .step      (pat_wr || pat_rd),
        .ptr       (ptr)
    );

    assign ram_addr = big ? ptr : {{BANK_W{1'b0}}, ptr[LOW_W-1:0]};

    hwcur_patram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(BIG_BYTES)) u_ram (
        .clk   (clk),
        .addr  (ram_addr),
        .we    (pat_wr),
        .re    (pat_rd),
        .wdata (host_wdata),
        .rdata (ram_rdata)
    );

    hwcur_pos #(
        .DATA_W(DATA_W), .POS_W(POS_W), .BIG_DIM(BIG_DIM),
        .SMALL_DIM(SMALL_DIM), .OUT_W(OUT_W), .OFF_W(OFF_W)
    ) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (host_wr),
        .sel     (host_sel),
        .wdata   (host_wdata),
        .rd_sel  (host_sel),
        .rd_byte (pos_byte),
        .big     (big),
        .eff_x   (eff_x),
        .eff_y   (eff_y),
        .row_off (row_off)
    );

    always_comb begin
        rd_d = rd_q;
        if (rd_fire) begin
            if (host_sel == SEL_PAT_DATA) begin
                rd_d.src    = RSRC_RAM;
                rd_d.byte_v = '0;
            end else begin
                rd_d.src    = RSRC_BYTE;
                rd_d.byte_v = is_pos_sel(host_sel) ? pos_byte : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '{src: RSRC_BYTE, byte_v: '0};
        else        rd_q <= rd_d;
    end

    assign host_rdata = (rd_q.src == RSRC_RAM) ? ram_rdata : rd_q.byte_v;

    // R11
    other_sel_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_fire && host_sel != SEL_PAT_DATA && !is_pos_sel(host_sel)) |=> host_rdata == 8'h00);

    // R9
    row_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_off == (big ? 6'd0 : 6'd32));
endmodule

// File: tb/hwcur_store_tb.sv
module hwcur_store_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  host_sel = 4'h0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic        size_big = 1'b1;
    logic [1:0]  bank_sel = 2'd0;
    logic        bank_load = 1'b0;
    logic [7:0]  host_rdata, s_rdata;
    logic signed [12:0] eff_x, eff_y, s_eff_x, s_eff_y;
    logic [5:0]  row_off, s_row_off;

    int total = 0, bad = 0;
    bit done = 1'b0;
    bit chk_en = 1'b0;

    // behavioural model
    byte unsigned m [1024];
    int    a = 0, px = 0, py = 0;
    int    exp_rd = 0;
    string rd_tag = "R1";
    string scen = "R2";

    always #10 clk = ~clk;

    hwcur_store u_dut (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .size_big(size_big), .bank_sel(bank_sel), .bank_load(bank_load),
        .eff_x(eff_x), .eff_y(eff_y), .row_off(row_off)
    );

    hwcur_store #(.LARGE_OK(1'b0)) u_dut_small (
        .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
        .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(s_rdata),
        .size_big(size_big), .bank_sel(bank_sel), .bank_load(bank_load),
        .eff_x(s_eff_x), .eff_y(s_eff_y), .row_off(s_row_off)
    );

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            a = 0; px = 0; py = 0; exp_rd = 0; rd_tag = "R1";
        end else begin
            int ea;
            bit step;
            ea = size_big ? a : (a & 255);
            step = 1'b0;
            if (host_wr) begin
                case (host_sel)
                    4'h0: a = (size_big ? int'(bank_sel) * 256 : 0) + int'(host_wdata);
                    4'hB: begin m[ea] = host_wdata; step = 1'b1; end
                    4'hC: px = (px & 32'hF00) | int'(host_wdata);
                    4'hD: px = (px & 32'h0FF) | (int'(host_wdata & 8'h0F) << 8);
                    4'hE: py = (py & 32'hF00) | int'(host_wdata);
                    4'hF: py = (py & 32'h0FF) | (int'(host_wdata & 8'h0F) << 8);
                    default: ;
                endcase
            end else if (host_rd) begin
                case (host_sel)
                    4'hB: begin exp_rd = m[ea]; step = 1'b1; rd_tag = scen; end
                    4'hC: begin exp_rd = px & 255; rd_tag = "R7"; end
                    4'hD: begin exp_rd = px >> 8;  rd_tag = "R7"; end
                    4'hE: begin exp_rd = py & 255; rd_tag = "R7"; end
                    4'hF: begin exp_rd = py >> 8;  rd_tag = "R7"; end
                    default: begin exp_rd = 0; rd_tag = "R11"; end
                endcase
            end
            if (step) a = size_big ? ((a + 1) & 1023) : ((a + 1) & 255);
            if (bank_load && size_big && !(host_wr && host_sel == 4'h0))
                a = (a & 255) | (int'(bank_sel) << 8);
        end
    end

    always @(negedge clk) begin
        if (chk_en && !done) begin
            check(rd_tag, int'(host_rdata), exp_rd);
            check("R8 eff_x", int'(eff_x), px - (size_big ? 64 : 32));
            check("R8 eff_y", int'(eff_y), py - (size_big ? 64 : 32));
            check("R9 row_off", int'(row_off), size_big ? 0 : 32);
            check("R10 small eff_x", int'(s_eff_x), px - 32);
            check("R10 small row_off", int'(s_row_off), 32);
        end
    end

    task automatic op(input logic [3:0] s, input bit w, input bit r,
                      input logic [7:0] d, input bit bl = 1'b0);
        @(negedge clk);
        #2;
        host_sel = s; host_wr = w; host_rd = r; host_wdata = d; bank_load = bl;
    endtask

    task automatic idle();
        op(4'h1, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #2 rst_n = 1'b1;
        chk_en = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 rdata", int'(host_rdata), 0);
        check("R1 eff_x", int'(eff_x), -64);
        check("R1 eff_y", int'(eff_y), -64);

        // fill all 1024 bytes in 64x64 mode (R2, R3 wrap at 1024)
        scen = "R2";
        size_big = 1'b1; bank_sel = 2'd0;
        op(4'h0, 1, 0, 8'h00);
        for (int i = 0; i < 1024; i++) op(4'hB, 1, 0, 8'((i * 37 + 11) & 255));
        // pointer wrapped to 0: read first bytes back
        scen = "R3";
        for (int i = 0; i < 4; i++) op(4'hB, 0, 1, 8'h00);

        // R4: index write in 64x64 mode takes bank bits
        scen = "R4";
        bank_sel = 2'd2;
        op(4'h0, 1, 0, 8'h10);
        for (int i = 0; i < 6; i++) op(4'hB, 0, 1, 8'h00);

        // R3: wrap 1023 -> 0 in 64x64 mode
        scen = "R3";
        bank_sel = 2'd3;
        op(4'h0, 1, 0, 8'hFE);
        for (int i = 0; i < 4; i++) op(4'hB, 1, 0, 8'hA0 + 8'(i));
        op(4'h0, 1, 0, 8'hFE);
        for (int i = 0; i < 4; i++) op(4'hB, 0, 1, 8'h00);

        // R3: wrap 255 -> 0 in 32x32 mode, bank bits cleared (R4)
        idle();
        size_big = 1'b0;
        op(4'h0, 1, 0, 8'hFE);
        for (int i = 0; i < 4; i++) op(4'hB, 1, 0, 8'h50 + 8'(i));
        op(4'h0, 1, 0, 8'hFE);
        for (int i = 0; i < 4; i++) op(4'hB, 0, 1, 8'h00);

        // R5: bank load in 32x32 mode ignored
        scen = "R5";
        op(4'h0, 1, 0, 8'h07);
        op(4'h1, 0, 0, 8'h00, 1'b1);
        op(4'hB, 1, 0, 8'hC3);
        op(4'h0, 1, 0, 8'h07);
        op(4'hB, 0, 1, 8'h00);
        // R5: bank load in 64x64 mode keeps low bits
        idle();
        size_big = 1'b1; bank_sel = 2'd0;
        op(4'h0, 1, 0, 8'h05);
        bank_sel = 2'd1;
        op(4'h1, 0, 0, 8'h00, 1'b1);
        op(4'hB, 1, 0, 8'h9E);
        op(4'h0, 1, 0, 8'h05);
        op(4'hB, 0, 1, 8'h00);
        // R5: bank load in the same cycle as a data read
        op(4'hB, 0, 1, 8'h00, 1'b1);
        op(4'hB, 0, 1, 8'h00);

        // R6/R7 coordinate registers
        op(4'hC, 1, 0, 8'h34);
        op(4'hD, 1, 0, 8'hA5);
        op(4'hC, 0, 1, 8'h00);
        op(4'hD, 0, 1, 8'h00);
        op(4'hE, 1, 0, 8'h10);
        op(4'hF, 1, 0, 8'hF0);
        op(4'hE, 0, 1, 8'h00);
        op(4'hF, 0, 1, 8'h00);
        // R6: low write keeps high nibble
        op(4'hF, 1, 0, 8'h0B);
        op(4'hE, 1, 0, 8'h02);
        op(4'hF, 0, 1, 8'h00);
        // R8: immediate size change
        idle();
        size_big = 1'b0;
        idle();
        size_big = 1'b1;
        idle();
        // R11: other select reads zero, simultaneous wr+rd is a write
        op(4'h3, 0, 1, 8'h00);
        op(4'h6, 0, 1, 8'h00);
        scen = "R11";
        op(4'h0, 1, 0, 8'h20);
        op(4'hB, 1, 1, 8'h77);
        op(4'h0, 1, 0, 8'h20);
        op(4'hB, 0, 1, 8'h00);

        // random mix
        scen = "R2";
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] s;
            int k;
            k = $urandom_range(0, 9);
            case (k)
                0: s = 4'h0;
                1, 2, 3: s = 4'hB;
                4: s = 4'hC;
                5: s = 4'hD;
                6: s = 4'hE;
                7: s = 4'hF;
                default: s = 4'($urandom_range(1, 10));
            endcase
            if ($urandom_range(0, 19) == 0) size_big = ~size_big;
            bank_sel = 2'($urandom_range(0, 3));
            op(s, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               8'($urandom_range(0, 255)), 1'($urandom_range(0, 9) == 0));
        end
        idle();
        idle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule